// File: doc/BRIEF.md
# Single-Accumulator Instruction Cycle Controller

This block is the control path and register set of a small processor with one accumulator. It steps through four kinds of machine cycle: instruction fetch, operand-address indirection, execute and interrupt entry. Each memory transfer goes through an address holding register (MAR) and a data buffer register (MBR), and each clock moves one value between registers. The block drives a single-port synchronous memory. That memory returns read data on the clock after the read strobe and accepts write data on the clock edge that ends a write-strobe cycle.

Instruction words are 16 bits wide:

| Bits | Field |
|------|-------|
| 15 | indirect flag |
| 14:12 | opcode |
| 11:0 | address |

The opcodes are:

| Code | Instruction |
|------|-------------|
| 0 | LOAD |
| 1 | STOR |
| 2 | ADD |
| 3 | SUB |
| 4 | JMP |
| 5 | return-from-interrupt |
| 6 | no-operation |
| 7 | halt |

A level-sensitive interrupt request is taken at the end of an execute cycle when the enable flag is set. Entry saves the program counter at memory word 0, disables further interrupts and continues at word 1. Return-from-interrupt reloads the program counter from word 0 and enables interrupts again.

Top module: `acp_cycle_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the block sets PC to 0x010, AC to 0 and the interrupt enable to 1, asserts no memory strobe and does not report halted.
- R2: A fetch lasts four cycles. The read strobe is high in the second cycle, with the address equal to PC. PC then increases by one, modulo 4096.
- R3: Bit 15 can be set on opcodes 0 to 4. In that case a three-cycle indirect cycle follows the fetch and reads the word at the address field. The low 12 bits of that word become the effective address. Bit 15 has no effect on opcodes 5, 6 and 7.
- R4: LOAD, ADD and SUB take four execute cycles. The read at the effective address is in the second cycle. AC becomes the operand, AC plus the operand, or AC minus the operand, all modulo 2^16.
- R5: STOR takes three execute cycles. The write strobe is high in the third cycle, with AC on the write data and the effective address on the address bus.
- R6: JMP takes one execute cycle and loads PC with the effective address.
- R7: The interrupt request is sampled only in the last execute cycle and only while the enable is 1. Entry takes four cycles, and the write strobe in the third cycle stores the zero-extended PC at address 0. Entry then sets PC to 1 and the enable to 0.
- R8: Return-from-interrupt takes four execute cycles. It reads address 0 in the second cycle and loads PC with the low 12 bits of that word. It sets the enable to 1 after the request has been sampled, so a request pending at its end waits for one more instruction.
- R9: After the halt opcode has been fetched, the block reports halted. It then asserts no strobe and changes no register, even when an interrupt request arrives.
- R10: Opcode 6 takes one execute cycle and changes neither AC nor PC.
- R11: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request, level |
| mem_rdata | input | 16 | Read data, valid the cycle after the read strobe |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (MBR) |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| int_en | output | 1 | Interrupt enable flag |
| halted | output | 1 | Halt reached |

## Verification
Memory strobes and addresses are due in fixed cycles:
- the fetch read comes in cycle 2 of an instruction;
- the indirect read comes in cycle 6;
- the operand read comes in cycle 2 of execute;
- the store write comes in cycle 3 of execute;
- the save write comes in cycle 3 of interrupt entry.

The bench reference model expands each instruction into its expected per-cycle bus activity and compares that list with the bus on every falling edge. AC, PC, the enable and halted become visible in the first cycle of the next instruction, and the model checks them exactly there. The model samples the interrupt request in the last execute cycle, with the enable value held before that cycle's update. The bench changes the request two nanoseconds after a rising edge, so the value the model samples is the value the design uses.

// File: rtl/acp_pkg.sv
// Shared types for the accumulator cycle controller.
// Assumes: a 4-bit state code and a 3-bit opcode field.
package acp_pkg;

    typedef enum logic [3:0] {
        S_F0, S_F1, S_F2, S_F3,
        S_I0, S_I1, S_I2,
        S_X0, S_X1, S_X2, S_X3,
        S_N0, S_N1, S_N2, S_N3,
        S_HALT
    } acp_state_e;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0, OP_STOR = 3'd1, OP_ADD = 3'd2, OP_SUB = 3'd3,
        OP_JMP  = 3'd4, OP_RTI  = 3'd5, OP_NOP = 3'd6, OP_HALT = 3'd7
    } acp_op_e;

    typedef enum logic [1:0] { MAR_PC, MAR_EA, MAR_SAVE } mar_src_e;
    typedef enum logic [1:0] { MBR_MEM, MBR_AC, MBR_PC } mbr_src_e;
    typedef enum logic       { PC_EA, PC_HANDLER } pc_src_e;
    typedef enum logic [1:0] { ALU_PASS, ALU_ADD, ALU_SUB } alu_op_e;

    // One register transfer per clock: at most one load enable group active.
    typedef struct packed {
        logic     mar_ld;
        mar_src_e mar_src;
        logic     mbr_ld;
        mbr_src_e mbr_src;
        logic     ir_ld;
        logic     pc_inc;
        logic     pc_ld;
        pc_src_e  pc_src;
        logic     ac_ld;
        alu_op_e  alu_op;
        logic     ie_set;
        logic     ie_clr;
        logic     mem_rd;
        logic     mem_wr;
    } acp_ctl_t;

endpackage

// File: rtl/acp_alu.sv
// Accumulator arithmetic: pass, add or subtract, modulo 2^DW.
// Assumes: purely combinational, no flags are produced.
module acp_alu
    import acp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y
);

    // Select the operation result.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/acp_dpath.sv
// Register set: MAR, MBR, opcode register, PC, AC and interrupt enable.
// Assumes: the sequencer raises one transfer per clock; the address part
// of the current instruction (or of the indirect word) stays in MBR.
module acp_dpath
    import acp_pkg::*;
#(
    parameter int DW           = 16,
    parameter int AW           = 12,
    parameter int RST_PC       = 16,
    parameter int SAVE_ADDR    = 0,
    parameter int HANDLER_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acp_ctl_t      ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mar_q,
    output logic [DW-1:0] mbr_q,
    output acp_op_e       ir_q,
    output logic [AW-1:0] pc_q,
    output logic [DW-1:0] ac_q,
    output logic          ie_q,
    output logic          mbr_ind,
    output acp_op_e       mbr_op
);

    localparam int OPW = 3;
    localparam int OPL = DW - 1 - OPW;

    logic [AW-1:0] ea;
    logic [DW-1:0] alu_y;

    assign ea      = mbr_q[AW-1:0];
    assign mbr_ind = mbr_q[DW-1];
    assign mbr_op  = acp_op_e'(mbr_q[OPL +: OPW]);

    acp_alu #(.DW(DW)) u_alu (
        .a  (ac_q),
        .b  (mbr_q),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    // Memory address register load.
    always_ff @(posedge clk) begin
        if (!rst_n) mar_q <= '0;
        else if (ctl.mar_ld) begin
            case (ctl.mar_src)
                MAR_PC:   mar_q <= pc_q;
                MAR_EA:   mar_q <= ea;
                default:  mar_q <= AW'(SAVE_ADDR);
            endcase
        end
    end

    // Memory buffer register load.
    always_ff @(posedge clk) begin
        if (!rst_n) mbr_q <= '0;
        else if (ctl.mbr_ld) begin
            case (ctl.mbr_src)
                MBR_MEM: mbr_q <= mem_rdata;
                MBR_AC:  mbr_q <= ac_q;
                default: mbr_q <= {{(DW-AW){1'b0}}, pc_q};
            endcase
        end
    end

    // Opcode register takes the opcode field of the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n)         ir_q <= OP_LOAD;
        else if (ctl.ir_ld) ir_q <= mbr_op;
    end

    // Program counter: increment during fetch, or load a new address.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= AW'(RST_PC);
        else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
        else if (ctl.pc_ld)  pc_q <= (ctl.pc_src == PC_HANDLER) ? AW'(HANDLER_ADDR) : ea;
    end

    // Accumulator update from the ALU.
    always_ff @(posedge clk) begin
        if (!rst_n)         ac_q <= '0;
        else if (ctl.ac_ld) ac_q <= alu_y;
    end

    // Interrupt enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n)          ie_q <= 1'b1;
        else if (ctl.ie_clr) ie_q <= 1'b0;
        else if (ctl.ie_set) ie_q <= 1'b1;
    end

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> pc_q == AW'($past(pc_q) + 1'b1));

    a_r7_ie_off: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ie_clr |=> !ie_q);

    a_r8_ie_on: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ie_set |=> ie_q);

endmodule

// File: rtl/acp_seq.sv
// Cycle sequencer: fetch, indirect, execute and interrupt-entry states.
// Assumes: memory read data is valid one clock after the read strobe;
// the interrupt request is examined only in the last execute state.
module acp_seq
    import acp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq,
    input  logic       ie,
    input  logic       mbr_ind,
    input  acp_op_e    mbr_op,
    input  acp_op_e    ir_op,
    output acp_ctl_t   ctl,
    output acp_state_e state_q
);

    acp_state_e nxt;
    logic       done;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_F0;
        else        state_q <= nxt;
    end

    // Transfer decode and next state for every cycle.
    always_comb begin
        ctl  = '0;
        nxt  = state_q;
        done = 1'b0;
        case (state_q)
            S_F0: begin ctl.mar_ld = 1'b1; ctl.mar_src = MAR_PC; nxt = S_F1; end
            S_F1: begin ctl.mem_rd = 1'b1; ctl.pc_inc = 1'b1; nxt = S_F2; end
            S_F2: begin ctl.mbr_ld = 1'b1; ctl.mbr_src = MBR_MEM; nxt = S_F3; end
            S_F3: begin
                ctl.ir_ld = 1'b1;
                if (mbr_op == OP_HALT)                   nxt = S_HALT;
                else if (mbr_ind && (mbr_op <= OP_JMP)) nxt = S_I0;
                else                                     nxt = S_X0;
            end
            S_I0: begin ctl.mar_ld = 1'b1; ctl.mar_src = MAR_EA; nxt = S_I1; end
            S_I1: begin ctl.mem_rd = 1'b1; nxt = S_I2; end
            S_I2: begin ctl.mbr_ld = 1'b1; ctl.mbr_src = MBR_MEM; nxt = S_X0; end
            S_X0: begin
                case (ir_op)
                    OP_LOAD, OP_ADD, OP_SUB, OP_STOR: begin
                        ctl.mar_ld = 1'b1; ctl.mar_src = MAR_EA; nxt = S_X1;
                    end
                    OP_RTI: begin ctl.mar_ld = 1'b1; ctl.mar_src = MAR_SAVE; nxt = S_X1; end
                    OP_JMP: begin ctl.pc_ld = 1'b1; ctl.pc_src = PC_EA; done = 1'b1; end
                    OP_NOP: done = 1'b1;
                    default: nxt = S_HALT;
                endcase
            end
            S_X1: begin
                if (ir_op == OP_STOR) begin ctl.mbr_ld = 1'b1; ctl.mbr_src = MBR_AC; end
                else                        ctl.mem_rd = 1'b1;
                nxt = S_X2;
            end
            S_X2: begin
                if (ir_op == OP_STOR) begin ctl.mem_wr = 1'b1; done = 1'b1; end
                else begin ctl.mbr_ld = 1'b1; ctl.mbr_src = MBR_MEM; nxt = S_X3; end
            end
            S_X3: begin
                done = 1'b1;
                case (ir_op)
                    OP_LOAD: begin ctl.ac_ld = 1'b1; ctl.alu_op = ALU_PASS; end
                    OP_ADD:  begin ctl.ac_ld = 1'b1; ctl.alu_op = ALU_ADD;  end
                    OP_SUB:  begin ctl.ac_ld = 1'b1; ctl.alu_op = ALU_SUB;  end
                    default: begin ctl.pc_ld = 1'b1; ctl.pc_src = PC_EA; ctl.ie_set = 1'b1; end
                endcase
            end
            S_N0: begin ctl.mbr_ld = 1'b1; ctl.mbr_src = MBR_PC; nxt = S_N1; end
            S_N1: begin ctl.mar_ld = 1'b1; ctl.mar_src = MAR_SAVE; nxt = S_N2; end
            S_N2: begin ctl.mem_wr = 1'b1; nxt = S_N3; end
            S_N3: begin
                ctl.pc_ld = 1'b1; ctl.pc_src = PC_HANDLER; ctl.ie_clr = 1'b1; nxt = S_F0;
            end
            default: nxt = S_HALT;
        endcase
        if (done) nxt = (irq && ie) ? S_N0 : S_F0;
    end

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_HALT |=> state_q == S_HALT);

    a_r7_entry_gate: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_N0 |-> ($past(irq) && $past(ie)));

    a_r7_entry_origin: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_N0 |-> ($past(state_q) == S_X0 || $past(state_q) == S_X2
                             || $past(state_q) == S_X3));

endmodule

// File: rtl/acp_cycle_ctrl.sv
// Top of the accumulator cycle controller: sequencer plus register set.
// Assumes: single-port synchronous memory, read latency one clock,
// write taken on the edge that ends the write-strobe cycle.
module acp_cycle_ctrl
    import acp_pkg::*;
#(
    parameter int DW           = 16,
    parameter int AW           = 12,
    parameter int RST_PC       = 16,
    parameter int SAVE_ADDR    = 0,
    parameter int HANDLER_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic          int_en,
    output logic          halted
);

    acp_ctl_t   ctl;
    acp_state_e st;
    acp_op_e    ir_op;
    acp_op_e    mbr_op;
    logic       mbr_ind;

    acp_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq     (irq),
        .ie      (int_en),
        .mbr_ind (mbr_ind),
        .mbr_op  (mbr_op),
        .ir_op   (ir_op),
        .ctl     (ctl),
        .state_q (st)
    );

    acp_dpath #(
        .DW(DW), .AW(AW), .RST_PC(RST_PC),
        .SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar_q     (mem_addr),
        .mbr_q     (mem_wdata),
        .ir_q      (ir_op),
        .pc_q      (pc),
        .ac_q      (acc),
        .ie_q      (int_en),
        .mbr_ind   (mbr_ind),
        .mbr_op    (mbr_op)
    );

    assign mem_rd = ctl.mem_rd;
    assign mem_wr = ctl.mem_wr;
    assign halted = (st == S_HALT);

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    a_r5_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && st == S_X2) |-> mem_wdata == acc);

    a_r7_save_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && st == S_N2) |-> (mem_addr == AW'(SAVE_ADDR)
                                    && mem_wdata == {{(DW-AW){1'b0}}, pc}));

endmodule

// File: tb/sim_acp_cycle_ctrl.sv
// Bench: behavioural reference model expands each instruction into its
// expected per-cycle bus activity and compares on every falling edge.
module sim_acp_cycle_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata, acc;
    logic [11:0] pc;
    logic        int_en, halted;

    always #5 clk = ~clk;

    acp_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .acc(acc), .pc(pc), .int_en(int_en),
        .halted(halted)
    );

    logic [15:0] ram [0:4095];
    logic [15:0] mir [0:4095];

    // Synchronous single-port memory model.
    always @(posedge clk) begin
        if (mem_wr) ram[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= ram[mem_addr];
    end

    typedef struct {
        logic        rd;
        logic        wr;
        logic [11:0] addr;
        logic [15:0] wd;
        int          kind;   // 0 plain, 1 last execute, 2 last entry, 3 halt
        string       req;
    } ev_t;

    ev_t q[$];

    int          total = 0, bad = 0, cyc = 0;
    logic [15:0] ac_m = '0;
    logic [11:0] pc_m = 12'h010;
    logic        ie_m = 1'b1, ie_nx = 1'b1, halted_m = 1'b0, take_m = 1'b0;
    logic        saw_save = 1'b0;
    logic        done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic rd, input logic wr, input logic [11:0] a,
                        input logic [15:0] wd, input int kind, input string req);
        ev_t e;
        e.rd = rd; e.wr = wr; e.addr = a; e.wd = wd; e.kind = kind; e.req = req;
        q.push_back(e);
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] v);
        ram[a] = v; mir[a] = v;
    endtask

    task automatic build_int();
        push(0, 0, 0, 0, 0, "R7");
        push(0, 0, 0, 0, 0, "R7");
        push(0, 1, 12'h000, {4'h0, pc_m}, 0, "R7");
        push(0, 0, 0, 0, 2, "R7");
        mir[0] = {4'h0, pc_m};
        pc_m = 12'h001;
    endtask

    task automatic build_instr();
        logic [15:0] w;
        logic [2:0]  op;
        logic [11:0] a;
        w  = mir[pc_m];
        op = w[14:12];
        a  = w[11:0];
        push(0, 0, 0, 0, 0, "R2");
        push(1, 0, pc_m, 0, 0, "R2");
        push(0, 0, 0, 0, 0, "R2");
        pc_m = pc_m + 12'd1;
        if (op == 3'd7) begin
            push(0, 0, 0, 0, 3, "R9");
            return;
        end
        push(0, 0, 0, 0, 0, "R2");
        if (w[15] && op <= 3'd4) begin
            push(0, 0, 0, 0, 0, "R3");
            push(1, 0, a, 0, 0, "R3");
            push(0, 0, 0, 0, 0, "R3");
            a = mir[a][11:0];
        end
        ie_nx = ie_m;
        case (op)
            3'd0, 3'd2, 3'd3: begin
                push(0, 0, 0, 0, 0, "R4");
                push(1, 0, a, 0, 0, "R4");
                push(0, 0, 0, 0, 0, "R4");
                push(0, 0, 0, 0, 1, "R4");
                if (op == 3'd0)      ac_m = mir[a];
                else if (op == 3'd2) ac_m = ac_m + mir[a];
                else                 ac_m = ac_m - mir[a];
            end
            3'd1: begin
                push(0, 0, 0, 0, 0, "R5");
                push(0, 0, 0, 0, 0, "R5");
                push(0, 1, a, ac_m, 1, "R5");
                mir[a] = ac_m;
            end
            3'd4: begin
                push(0, 0, 0, 0, 1, "R6");
                pc_m = a;
            end
            3'd5: begin
                push(0, 0, 0, 0, 0, "R8");
                push(1, 0, 12'h000, 0, 0, "R8");
                push(0, 0, 0, 0, 0, "R8");
                push(0, 0, 0, 0, 1, "R8");
                pc_m  = mir[0][11:0];
                ie_nx = 1'b1;
            end
            default: push(0, 0, 0, 0, 1, "R10");
        endcase
    endtask

    // One model step, called at each falling edge.
    task automatic step();
        ev_t e;
        if (q.size() == 0) begin
            chk("R4", "acc at boundary", 32'(acc), 32'(ac_m));
            chk("R6", "pc at boundary", 32'(pc), 32'(pc_m));
            chk("R7", "int_en at boundary", 32'(int_en), 32'(ie_m));
            chk("R9", "halted at boundary", 32'(halted), 32'(halted_m));
            if (halted_m)    push(0, 0, 0, 0, 0, "R9");
            else if (take_m) build_int();
            else             build_instr();
        end
        e = q.pop_front();
        chk(e.req, "mem_rd", 32'(mem_rd), 32'(e.rd));
        chk(e.req, "mem_wr", 32'(mem_wr), 32'(e.wr));
        chk("R11", "single strobe", 32'(mem_rd && mem_wr), 32'(0));
        if (e.rd || e.wr) chk(e.req, "mem_addr", 32'(mem_addr), 32'(e.addr));
        if (e.wr)         chk(e.req, "mem_wdata", 32'(mem_wdata), 32'(e.wd));
        case (e.kind)
            1: begin take_m = irq && ie_m; ie_m = ie_nx; end
            2: begin take_m = 1'b0; ie_m = 1'b0; end
            3: halted_m = 1'b1;
            default: ;
        endcase
    endtask

    // Detect the interrupt save write for the stimulus block.
    always @(negedge clk) if (rst_n && mem_wr && mem_addr == 12'h000) saw_save <= 1'b1;

    // Interrupt request stimulus, changed just after a rising edge.
    initial begin
        wait (cyc == 100);
        @(posedge clk); #2 irq = 1'b1;
        wait (saw_save);
        @(posedge clk); #2 irq = 1'b0;
        wait (cyc == 220);
        @(posedge clk); #2 irq = 1'b1;   // held across handler: R7 gating, R8 delay
        wait (cyc == 280);
        @(posedge clk); #2 irq = 1'b0;
        wait (cyc == 620);
        @(posedge clk); #2 irq = 1'b1;   // after halt: R9 ignore
        wait (cyc == 660);
        @(posedge clk); #2 irq = 1'b0;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin ram[i] = '0; mir[i] = '0; end
        // handler at 1: ADD 0x109, STOR 0x10A, RTI with bit 15 set (R3 ignore)
        put(12'h001, 16'h2109); put(12'h002, 16'h110A); put(12'h003, 16'hD000);
        // main program from 0x010
        put(12'h010, 16'h0100);  // LOAD 0x100
        put(12'h011, 16'h2101);  // ADD 0x101
        put(12'h012, 16'hB102);  // SUB indirect via 0x102
        put(12'h013, 16'h1104);  // STOR 0x104
        put(12'h014, 16'h2105);  // ADD 0xFFFF, wraps (R4)
        put(12'h015, 16'h9106);  // STOR indirect via 0x106
        put(12'h016, 16'h4020);  // JMP 0x020
        put(12'h017, 16'h7000);  // HALT, skipped
        put(12'h020, 16'h6000);  // NOP (R10)
        put(12'h021, 16'hC108);  // JMP indirect via 0x108
        put(12'h030, 16'h0104);  // LOAD 0x104
        for (int a = 12'h031; a < 12'h050; a++) put(12'(a), 16'h2109);
        put(12'h050, 16'hE000);  // NOP with bit 15 set
        put(12'h051, 16'hF000);  // HALT with bit 15 set
        put(12'h100, 16'h1234); put(12'h101, 16'h0F0F); put(12'h102, 16'h0103);
        put(12'h103, 16'h0005); put(12'h105, 16'hFFFF); put(12'h106, 16'h0107);
        put(12'h108, 16'h0030); put(12'h109, 16'h0001);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset mem_rd", 32'(mem_rd), 32'(0));
        chk("R1", "reset mem_wr", 32'(mem_wr), 32'(0));
        chk("R1", "reset pc", 32'(pc), 32'h010);
        chk("R1", "reset acc", 32'(acc), 32'(0));
        chk("R1", "reset int_en", 32'(int_en), 32'(1));
        chk("R1", "reset halted", 32'(halted), 32'(0));
        rst_n = 1'b1;
        for (int n = 0; n < 800; n++) begin
            step();
            @(negedge clk);
        end
        chk("R9", "program halted", 32'(halted), 32'(1));
        chk("R7", "interrupt taken", 32'(saw_save), 32'(1));
        chk("R5", "mem 0x104", 32'(ram[12'h104]), 32'(mir[12'h104]));
        chk("R5", "mem 0x107", 32'(ram[12'h107]), 32'(mir[12'h107]));
        chk("R5", "mem 0x10A", 32'(ram[12'h10A]), 32'(mir[12'h10A]));
        chk("R7", "mem 0x000", 32'(ram[12'h000]), 32'(mir[12'h000]));
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule